// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt sources and presents one IRQ line per CPU, for up to four CPUs. Every source passes two independent gates before it reaches a CPU. The first is a single global enable per source. The second is a mask held separately for each CPU. Sources above the per-CPU class must also be routed to a CPU by a per-source control register. Software never writes bitmaps to change the gates. It writes a source number to a "set" or a "clear" register, so no read-modify-write sequence is needed.

The register port is a simple one-cycle request. Each request carries a window select: shared or local. The local window is one address range. The block resolves it to the CPU whose identifier comes with the request. That CPU masks or unmasks its own gate through this window, and reads an acknowledge register that returns the lowest-numbered source it can currently take. Read data comes back in the cycle after the request.

The response path is a two-state machine. In ST_IDLE no data is returned. A read request moves it to ST_RESP, on the transition named "read accepted". In ST_RESP the captured data is presented for one cycle. Another read keeps it in ST_RESP ("back-to-back read"), and anything else returns it to ST_IDLE ("response done"). Writes never change the state.

Top module: `dual_gate_irq_ctrl`

## Requirements
- R1: After reset, irq_out is all zero and rd_valid is low. Every source is globally disabled and masked for every CPU. Every source control register reads 0, and the acknowledge read returns 0x3FF.
- R2: A shared-window write to offset 0x30 with data n enables source n globally. A shared-window write to offset 0x34 with data n disables it. A disabled source reaches no CPU.
- R3: A local-window write to offset 0x48 with data n masks source n for the CPU given on acc_cpu. A local-window write to offset 0x4C with data n unmasks it for that CPU. The masks of the other CPUs are left unchanged.
- R4: The source control register of source n sits at shared offset 0x100 + 4n. Bits [3:0] are the IRQ routing bits, where bit c routes the source to CPU c. Bits [11:8] are the FIQ routing bits, where bit 8+c belongs to CPU c. All other bits read 0.
- R5: For a source numbered above 28, irq_out[c] is high when all four of these hold: the source level is high, the source is globally enabled, it is unmasked for CPU c, and IRQ routing bit c is set. The output changes in the cycle after the condition changes.
- R6: Sources 0 through 28 are of the per-CPU class. For them the routing bits are ignored, so delivery depends only on the level, the global enable and the CPU's mask. Source 29 already needs its routing bit.
- R7: A local-window read of offset 0x44 returns, in bits [9:0], the lowest-numbered source deliverable to the requesting CPU. It returns 0x3FF when that CPU has nothing deliverable. Bits [31:10] read 0. The read does not clear anything.
- R8: A shared-window read of offset 0x00 returns the number of implemented sources in bits [11:2], which is 0x100 for 64 sources. Writes to this offset have no effect.
- R9: A read request is answered by rd_valid high with its data in the next cycle. A write request never raises rd_valid.
- R10: A set or clear write whose data is not below the number of sources is ignored. In particular, it does not alias onto a lower source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NUM_SRC | Level of each interrupt source |
| acc_valid | input | 1 | Register request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_local | input | 1 | 1 = local (per-CPU) window, 0 = shared window |
| acc_cpu | input | CPU_W | Identifier of the requesting CPU |
| acc_addr | input | 12 | Byte offset within the window |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (cycle after a read) |
| rd_data | output | 32 | Read data |
| irq_out | output | NUM_CPU | Interrupt line to each CPU |

## Verification
The hardest situation to reach from the ports is one where the two gates and the routing disagree for different CPUs at the same time. An example is a shared source that is enabled, unmasked for two CPUs and routed to only one of them, while a per-CPU source with zero routing is live on a third CPU. The stimulus builds this up one set or clear write at a time. After each write it checks the whole irq_out vector, so a gate that leaks to the wrong CPU shows up. The sources 28 and 29 are set up identically with empty routing, which exercises the class boundary. A set-enable write of the first out-of-range number, which would alias to source 0 if truncated, is checked against a live but disabled source 0.

// File: rtl/dgic_pkg.sv
package dgic_pkg;
    localparam int ADDR_W  = 12;
    localparam int ID_W    = 10;
    localparam int FIQ_LSB = 8;
    localparam logic [ID_W-1:0] NO_IRQ = '1;

    localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_EN_SET   = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR   = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_SRC_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_ACK      = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_MSK_SET  = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_MSK_CLR  = 12'h04C;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/dgic_bus_fsm.sv
module dgic_bus_fsm
    import dgic_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64,
    parameter int CPU_W   = 2,
    parameter int SRC_W   = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_valid,
    input  logic                             acc_write,
    input  logic                             acc_local,
    input  logic [CPU_W-1:0]                 acc_cpu,
    input  logic [ADDR_W-1:0]                acc_addr,
    input  logic [31:0]                      acc_wdata,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0]  rt_irq,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0]  rt_fiq,
    input  logic [NUM_CPU-1:0][ID_W-1:0]     ack_id,
    output logic                             en_set,
    output logic                             en_clr,
    output logic                             mk_set,
    output logic                             mk_clr,
    output logic [SRC_W-1:0]                 num,
    output logic                             ctl_wr,
    output logic [SRC_W-1:0]                 ctl_idx,
    output logic [NUM_CPU-1:0]               ctl_irq,
    output logic [NUM_CPU-1:0]               ctl_fiq,
    output logic                             rd_valid,
    output logic [31:0]                      rd_data
);
    logic              wr, rd, num_ok, ctl_hit, is_ctrl, is_ack;
    logic [ADDR_W-1:0] src_off;
    logic [31:0]       rd_next, rdata_q;
    bus_state_e        state, state_nx;

    assign wr      = acc_valid &&  acc_write;
    assign rd      = acc_valid && !acc_write;
    assign num_ok  = acc_wdata < 32'(NUM_SRC);
    assign num     = acc_wdata[SRC_W-1:0];
    assign src_off = acc_addr - OFF_SRC_BASE;
    assign ctl_hit = !acc_local && (acc_addr >= OFF_SRC_BASE) &&
                     (src_off[1:0] == 2'b00) && ((src_off >> 2) < ADDR_W'(NUM_SRC));
    assign ctl_idx = src_off[SRC_W+1:2];
    assign is_ctrl = !acc_local && (acc_addr == OFF_CTRL);
    assign is_ack  =  acc_local && (acc_addr == OFF_ACK);

    assign en_set  = wr && !acc_local && (acc_addr == OFF_EN_SET)  && num_ok;
    assign en_clr  = wr && !acc_local && (acc_addr == OFF_EN_CLR)  && num_ok;
    assign mk_set  = wr &&  acc_local && (acc_addr == OFF_MSK_SET) && num_ok;
    assign mk_clr  = wr &&  acc_local && (acc_addr == OFF_MSK_CLR) && num_ok;
    assign ctl_wr  = wr && ctl_hit;
    assign ctl_irq = acc_wdata[NUM_CPU-1:0];
    assign ctl_fiq = acc_wdata[FIQ_LSB +: NUM_CPU];

    always_comb begin
        rd_next = '0;
        if (is_ctrl) begin
            rd_next[ID_W+1:2] = ID_W'(NUM_SRC);
        end else if (ctl_hit) begin
            rd_next[NUM_CPU-1:0]         = rt_irq[ctl_idx];
            rd_next[FIQ_LSB +: NUM_CPU]  = rt_fiq[ctl_idx];
        end else if (is_ack) begin
            rd_next[ID_W-1:0] = ack_id[acc_cpu];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state <= state_nx;
            if (rd) rdata_q <= rd_next;
        end
    end

    // Transitions: read accepted, back-to-back read, response done
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = rd ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state)
            ST_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            ST_RESP: begin
                rd_valid = 1'b1;
                rd_data  = rdata_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

    p_rdv_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_valid);
    p_no_rdv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rd_valid);
    p_ctrl_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && is_ctrl) |=> (rd_data == (32'(NUM_SRC) << 2)));
    p_ack_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && is_ack) |=> ((rd_data[31:ID_W] == '0) &&
        ((rd_data[ID_W-1:0] == NO_IRQ) || (rd_data[ID_W-1:0] < ID_W'(NUM_SRC)))));
endmodule

// File: rtl/dgic_gate_state.sv
module dgic_gate_state #(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64,
    parameter int CPU_W   = 2,
    parameter int SRC_W   = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en_set,
    input  logic                             en_clr,
    input  logic                             mk_set,
    input  logic                             mk_clr,
    input  logic [SRC_W-1:0]                 num,
    input  logic [CPU_W-1:0]                 cpu,
    input  logic                             ctl_wr,
    input  logic [SRC_W-1:0]                 ctl_idx,
    input  logic [NUM_CPU-1:0]               ctl_irq,
    input  logic [NUM_CPU-1:0]               ctl_fiq,
    output logic [NUM_SRC-1:0]               en,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]  rt_irq,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]  rt_fiq
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[s] <= 1'b0;
            end else if (en_set && (num == SRC_W'(s))) begin
                en[s] <= 1'b1;
            end else if (en_clr && (num == SRC_W'(s))) begin
                en[s] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rt_irq[s] <= '0;
                rt_fiq[s] <= '0;
            end else if (ctl_wr && (ctl_idx == SRC_W'(s))) begin
                rt_irq[s] <= ctl_irq;
                rt_fiq[s] <= ctl_fiq;
            end
        end

        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask[c][s] <= 1'b1;
                end else if (cpu == CPU_W'(c) && num == SRC_W'(s)) begin
                    if (mk_set)      mask[c][s] <= 1'b1;
                    else if (mk_clr) mask[c][s] <= 1'b0;
                end
            end
        end
    end

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> en[$past(num)]);
    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en[$past(num)]);
    p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> ($stable(rt_irq) && $stable(rt_fiq)));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
        p_mask_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((mk_set || mk_clr) && (cpu != CPU_W'(c))) |=> $stable(mask[c]));
    end
endmodule

// File: rtl/dgic_deliver.sv
module dgic_deliver
    import dgic_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SRC    = 64,
    parameter int LAST_LOCAL = 28
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               src_level,
    input  logic [NUM_SRC-1:0]               en,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0]  rt_irq,
    output logic [NUM_CPU-1:0][ID_W-1:0]     ack_id,
    output logic [NUM_CPU-1:0]               irq_out
);
    logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (s <= LAST_LOCAL) begin : g_local
                assign pend[c][s] = src_level[s] && en[s] && !mask[c][s];
            end else begin : g_shared
                assign pend[c][s] = src_level[s] && en[s] && !mask[c][s] && rt_irq[s][c];
            end
        end

        always_comb begin
            ack_id[c] = NO_IRQ;
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (pend[c][s]) ack_id[c] = ID_W'(s);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) irq_out[c] <= 1'b0;
            else        irq_out[c] <= |pend[c];
        end

        p_irq_needs_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[c] |-> $past(|(src_level & en & ~mask[c])));
        p_ack_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_id[c] != NO_IRQ) |-> (ack_id[c] < ID_W'(NUM_SRC)));
    end
endmodule

// File: rtl/dual_gate_irq_ctrl.sv
module dual_gate_irq_ctrl
    import dgic_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SRC    = 64,
    parameter int LAST_LOCAL = 28,
    localparam int CPU_W     = $clog2(NUM_CPU),
    localparam int SRC_W     = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_level,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_local,
    input  logic [CPU_W-1:0]     acc_cpu,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [31:0]          acc_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [NUM_CPU-1:0]   irq_out
);
    logic                             en_set, en_clr, mk_set, mk_clr, ctl_wr;
    logic [SRC_W-1:0]                 num, ctl_idx;
    logic [NUM_CPU-1:0]               ctl_irq, ctl_fiq;
    logic [NUM_SRC-1:0]               en;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]  rt_irq, rt_fiq;
    logic [NUM_CPU-1:0][ID_W-1:0]     ack_id;

    dgic_bus_fsm #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .CPU_W(CPU_W), .SRC_W(SRC_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_local(acc_local), .acc_cpu(acc_cpu), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rt_irq(rt_irq), .rt_fiq(rt_fiq), .ack_id(ack_id),
        .en_set(en_set), .en_clr(en_clr), .mk_set(mk_set), .mk_clr(mk_clr), .num(num),
        .ctl_wr(ctl_wr), .ctl_idx(ctl_idx), .ctl_irq(ctl_irq), .ctl_fiq(ctl_fiq),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    dgic_gate_state #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .CPU_W(CPU_W), .SRC_W(SRC_W)) u_state (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr), .mk_set(mk_set),
        .mk_clr(mk_clr), .num(num), .cpu(acc_cpu), .ctl_wr(ctl_wr), .ctl_idx(ctl_idx),
        .ctl_irq(ctl_irq), .ctl_fiq(ctl_fiq), .en(en), .mask(mask),
        .rt_irq(rt_irq), .rt_fiq(rt_fiq)
    );

    dgic_deliver #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .LAST_LOCAL(LAST_LOCAL)) u_deliver (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .en(en), .mask(mask),
        .rt_irq(rt_irq), .ack_id(ack_id), .irq_out(irq_out)
    );
endmodule

// File: tb/tb_dual_gate_irq_ctrl.sv
module tb_dual_gate_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_level = '0;
    logic            acc_valid = 1'b0, acc_write = 1'b0, acc_local = 1'b0;
    logic [1:0]      acc_cpu = '0;
    logic [11:0]     acc_addr = '0;
    logic [31:0]     acc_wdata = '0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic [3:0]      irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    dual_gate_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_local(acc_local), .acc_cpu(acc_cpu),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(bit w, bit loc, int cpu, logic [11:0] addr, logic [31:0] data);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = w; acc_local = loc;
        acc_cpu = 2'(cpu); acc_addr = addr; acc_wdata = data;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic wr_sh(logic [11:0] addr, logic [31:0] data);
        access(1'b1, 1'b0, 0, addr, data);
    endtask

    task automatic wr_lc(int cpu, logic [11:0] addr, logic [31:0] data);
        access(1'b1, 1'b1, cpu, addr, data);
    endtask

    task automatic rd_chk(bit loc, int cpu, logic [11:0] addr, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, loc, cpu, addr, 32'h0);
    endtask

    task automatic irq_chk(logic [3:0] exp, string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, 32'(irq_out), 32'(exp));
    endtask

    function automatic logic [11:0] ctl(int n);
        return 12'(12'h100 + 4 * n);
    endfunction

    // Monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected rd_valid", 32'(rd_valid), 32'h0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq_out after reset", 32'(irq_out), 32'h0);
        check("R1 rd_valid after reset", 32'(rd_valid), 32'h0);
        rd_chk(1'b0, 0, ctl(40), 32'h0, "R1 source control reset");
        rd_chk(1'b1, 0, 12'h044, 32'h3FF, "R1 ack empty after reset");

        // R8 control register
        rd_chk(1'b0, 0, 12'h000, 32'h100, "R8 source count");
        wr_sh(12'h000, 32'hFFFF_FFFF);
        rd_chk(1'b0, 0, 12'h000, 32'h100, "R8 read-only after write");

        // R4 source control fields
        wr_sh(ctl(40), 32'hFFFF_FFFF);
        rd_chk(1'b0, 0, ctl(40), 32'h0000_0F0F, "R4 implemented bits");
        wr_sh(ctl(40), 32'h0000_0002);
        rd_chk(1'b0, 0, ctl(40), 32'h0000_0002, "R4 route cpu1");

        // R10 out-of-range number must not alias onto source 0
        src_level[0] = 1'b1;
        wr_lc(0, 12'h04C, 32'd0);
        irq_chk(4'b0000, "R2 disabled source blocked");
        wr_sh(12'h030, 32'd64);
        irq_chk(4'b0000, "R10 set-enable 64 ignored");
        rd_chk(1'b1, 0, 12'h044, 32'h3FF, "R10 ack after ignored write");
        wr_sh(12'h030, 32'd0);
        irq_chk(4'b0001, "R2 enable source 0");
        wr_sh(12'h034, 32'd64);
        irq_chk(4'b0001, "R10 clear-enable 64 ignored");
        wr_sh(12'h034, 32'd0);
        irq_chk(4'b0000, "R2 disable source 0");
        src_level[0] = 1'b0;

        // R5 / R3 shared source 40
        src_level[40] = 1'b1;
        wr_sh(12'h030, 32'd40);
        irq_chk(4'b0000, "R3 masked on all cpus");
        wr_lc(1, 12'h04C, 32'd40);
        irq_chk(4'b0010, "R5 delivered to cpu1");
        wr_lc(2, 12'h04C, 32'd40);
        irq_chk(4'b0010, "R5 cpu2 unmasked but not routed");
        wr_sh(ctl(40), 32'h0000_0006);
        irq_chk(4'b0110, "R5 routed to cpu1 and cpu2");
        wr_lc(1, 12'h048, 32'd40);
        irq_chk(4'b0100, "R3 cpu1 masks only itself");
        src_level[40] = 1'b0;
        irq_chk(4'b0000, "R5 level low");
        src_level[40] = 1'b1;
        irq_chk(4'b0100, "R5 level high again");
        wr_sh(12'h034, 32'd40);
        irq_chk(4'b0000, "R2 global disable source 40");

        // R6 per-CPU class source 5 with empty routing
        src_level[5] = 1'b1;
        wr_sh(12'h030, 32'd5);
        wr_lc(0, 12'h04C, 32'd5);
        irq_chk(4'b0001, "R6 per-cpu source ignores routing");

        // R7 acknowledge
        rd_chk(1'b1, 0, 12'h044, 32'd5, "R7 ack source 5");
        rd_chk(1'b1, 0, 12'h044, 32'd5, "R7 ack does not clear");
        src_level[3] = 1'b1;
        wr_sh(12'h030, 32'd3);
        wr_lc(0, 12'h04C, 32'd3);
        rd_chk(1'b1, 0, 12'h044, 32'd3, "R7 lowest number wins");
        rd_chk(1'b1, 3, 12'h044, 32'h3FF, "R7 cpu3 nothing pending");
        rd_chk(1'b1, 2, 12'h044, 32'h3FF, "R7 cpu2 source disabled");

        // R6 boundary 28 / 29
        src_level[28] = 1'b1;
        src_level[29] = 1'b1;
        wr_sh(12'h030, 32'd29);
        wr_lc(3, 12'h04C, 32'd29);
        irq_chk(4'b0001, "R6 source 29 needs routing");
        wr_sh(12'h030, 32'd28);
        wr_lc(3, 12'h04C, 32'd28);
        irq_chk(4'b1001, "R6 source 28 skips routing");
        rd_chk(1'b1, 3, 12'h044, 32'd28, "R7 cpu3 ack 28");
        wr_sh(ctl(29), 32'h0000_0008);
        irq_chk(4'b1001, "R5 source 29 routed to cpu3");
        wr_sh(12'h034, 32'd28);
        rd_chk(1'b1, 3, 12'h044, 32'd29, "R5 cpu3 ack 29 once routed");
        rd_chk(1'b1, 1, 12'h044, 32'h3FF, "R3 cpu1 unaffected by cpu3 unmask");

        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 every read answered", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule